// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the main sequencing state machine of a multicycle load/store processor. Each cycle it reads the 6-bit opcode held in the instruction register and drives the control lines of the shared datapath. These lines cover PC update, memory access, instruction latch, register-file write, ALU operand and operation selects, PC source, and the writes to the exception-PC and cause registers. Every instruction starts with a fetch cycle and a decode cycle. It then takes a path that depends on its opcode class: memory, register-register, branch, jump, jump-with-link, or illegal.

Every opcode outside the recognised set goes through one shared exception state. That state saves the faulting address, records an undefined-instruction cause, and redirects the PC to a fixed vector. The state register has four flip-flops. Its codes are Gray-adjacent around the register-register loop, so that the most frequent instruction switches exactly one state flip-flop per cycle. The current state code is brought out on `state_o`.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: Opcode classes are: 0x00 register-register; 0x23 load and 0x2B store (memory class); 0x04 branch; 0x02 jump and 0x03 jump-with-link (jump class). Every other 6-bit value is illegal.
- R2: While `rst_ni` is low, the state is forced to fetch (0000) at once, without waiting for a clock edge. After release, execution starts from fetch.
- R3: In fetch (0000) the outputs are pc_write=1, mem_read=1, ir_write=1, alu_b_sel=1 (constant 4), with addr_sel=0, alu_a_sel=0, alu_op=0 (add) and pc_sel=0. Decode (0001) always follows fetch and drives alu_b_sel=3 (shifted offset) with alu_op=0. In every state, any field not listed for it is 0.
- R4: A register-register instruction visits 0000, 0001, 0011, 0010 and returns to 0000. Each of these four transitions changes exactly one state bit. Execute drives alu_a_sel=1, alu_b_sel=0, alu_op=2 (function field). Write-back drives reg_write=1, reg_dst=1 (rd) and wb_sel=0 (ALU result).
- R5: A load visits 0000, 0001, 0101, 0111, 0110 and returns to 0000. Address state: alu_a_sel=1, alu_b_sel=2. Read state: mem_read=1, addr_sel=1. Write-back: reg_write=1, reg_dst=0, wb_sel=1 (memory data).
- R6: A store visits 0000, 0001, 0101, 0100 and returns to 0000. The write state drives mem_write=1 and addr_sel=1.
- R7: A branch visits 0000, 0001, 1001 and returns to 0000. Its final state drives pc_write_cond=1, pc_sel=1 (stored target), alu_a_sel=1, alu_b_sel=0 and alu_op=1 (subtract).
- R8: A plain jump visits 0000, 0001, 1011 and returns to 0000. Its final state drives pc_write=1 and pc_sel=2 (concatenated target).
- R9: A jump-with-link visits 0000, 0001, 1010 and returns to 0000. Its final state drives pc_write=1, pc_sel=2, reg_write=1, reg_dst=2 (register 31) and wb_sel=2 (incremented PC).
- R10: Every illegal opcode goes from decode to the single exception state 1000 and then returns to fetch. The exception state drives pc_write=1, pc_sel=3 (vector), alu_b_sel=1, alu_op=1 (PC minus 4), epc_write=1 and cause_write=1.
- R11: `state_o` only ever holds one of the twelve codes above. Any other code falls back to fetch on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current state code |
| pc_write_o | output | 1 | Unconditional PC write |
| pc_write_cond_o | output | 1 | PC write qualified by ALU zero |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_write_o | output | 1 | Instruction register write |
| reg_write_o | output | 1 | Register file write |
| reg_dst_o | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| wb_sel_o | output | 2 | Write data: 0 ALU output, 1 memory data, 2 PC |
| alu_a_sel_o | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B: 0 register B, 1 constant 4, 2 offset, 3 offset shifted by 2 |
| alu_op_o | output | 2 | 0 add, 1 subtract, 2 use function field |
| pc_sel_o | output | 2 | PC source: 0 ALU, 1 ALU output register, 2 jump target, 3 exception vector |
| epc_write_o | output | 1 | Exception PC register write |
| cause_write_o | output | 1 | Cause register write |

## Verification
The sequencer is Moore: all control lines are a function of the state alone. A wrong state code therefore shows up on `state_o` and on the whole control vector in the same cycle it is entered. A wrong transition shows up one clock after the decision that caused it. Each class path is traced state by state, with several illegal opcodes chosen to sit next to legal ones. Bit flips between consecutive states are counted on the register-register loop, so a code assignment that breaks the single-toggle property is caught at the transition where it happens.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W    = 6;
  localparam int STATE_W = 4;
  localparam int SEL_W   = 2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_J     = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2B;

  // Register-register loop is Gray: 0000 -> 0001 -> 0011 -> 0010 -> 0000
  typedef enum logic [STATE_W-1:0] {
    ST_FETCH    = 4'b0000,
    ST_DECODE   = 4'b0001,
    ST_R_EXEC   = 4'b0011,
    ST_R_WB     = 4'b0010,
    ST_MEM_ADDR = 4'b0101,
    ST_MEM_RD   = 4'b0111,
    ST_LD_WB    = 4'b0110,
    ST_MEM_WR   = 4'b0100,
    ST_BR_DONE  = 4'b1001,
    ST_J_DONE   = 4'b1011,
    ST_JAL_DONE = 4'b1010,
    ST_EXC      = 4'b1000
  } state_e;

  typedef enum logic [2:0] {
    CL_MEM, CL_RTYPE, CL_BRANCH, CL_JUMP, CL_ILLEGAL
  } op_class_e;

  typedef struct packed {
    op_class_e cls;
    logic      is_store;
    logic      is_link;
  } op_info_t;

  typedef struct packed {
    logic             pc_write;
    logic             pc_write_cond;
    logic             mem_read;
    logic             mem_write;
    logic             addr_sel;
    logic             ir_write;
    logic             reg_write;
    logic [SEL_W-1:0] reg_dst;
    logic [SEL_W-1:0] wb_sel;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_sel;
    logic             epc_write;
    logic             cause_write;
  } ctrl_t;

  localparam logic [SEL_W-1:0] B_REG = 2'd0, B_FOUR = 2'd1, B_OFS = 2'd2, B_OFS_SH = 2'd3;
  localparam logic [SEL_W-1:0] AOP_ADD = 2'd0, AOP_SUB = 2'd1, AOP_FUNCT = 2'd2;
  localparam logic [SEL_W-1:0] PCS_ALU = 2'd0, PCS_ALUOUT = 2'd1, PCS_JUMP = 2'd2, PCS_VEC = 2'd3;
  localparam logic [SEL_W-1:0] DST_RT = 2'd0, DST_RD = 2'd1, DST_RA = 2'd2;
  localparam logic [SEL_W-1:0] WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC = 2'd2;
endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output op_info_t        info_o
);
  always_comb begin
    info_o = '{cls: CL_ILLEGAL, is_store: 1'b0, is_link: 1'b0};
    unique case (opcode_i)
      OP_RTYPE: info_o.cls = CL_RTYPE;
      OP_LW:    info_o.cls = CL_MEM;
      OP_SW:    begin info_o.cls = CL_MEM;  info_o.is_store = 1'b1; end
      OP_BEQ:   info_o.cls = CL_BRANCH;
      OP_J:     info_o.cls = CL_JUMP;
      OP_JAL:   begin info_o.cls = CL_JUMP; info_o.is_link = 1'b1; end
      default:  info_o.cls = CL_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e   state_i,
  input  op_info_t info_i,
  output state_e   next_o
);
  always_comb begin
    next_o = ST_FETCH;
    case (state_i)
      ST_FETCH:  next_o = ST_DECODE;
      ST_DECODE: begin
        case (info_i.cls)
          CL_MEM:    next_o = ST_MEM_ADDR;
          CL_RTYPE:  next_o = ST_R_EXEC;
          CL_BRANCH: next_o = ST_BR_DONE;
          CL_JUMP:   next_o = info_i.is_link ? ST_JAL_DONE : ST_J_DONE;
          default:   next_o = ST_EXC;
        endcase
      end
      ST_MEM_ADDR: next_o = info_i.is_store ? ST_MEM_WR : ST_MEM_RD;
      ST_MEM_RD:   next_o = ST_LD_WB;
      ST_R_EXEC:   next_o = ST_R_WB;
      default:     next_o = ST_FETCH; // completion states and unused codes
    endcase
  end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (state_i)
      ST_FETCH: begin
        ctrl_o.pc_write  = 1'b1;
        ctrl_o.mem_read  = 1'b1;
        ctrl_o.ir_write  = 1'b1;
        ctrl_o.alu_b_sel = B_FOUR;
        ctrl_o.alu_op    = AOP_ADD;
        ctrl_o.pc_sel    = PCS_ALU;
      end
      ST_DECODE: ctrl_o.alu_b_sel = B_OFS_SH; // branch target into ALU output reg
      ST_MEM_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = B_OFS;
      end
      ST_MEM_RD: begin
        ctrl_o.mem_read = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_LD_WB: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.reg_dst   = DST_RT;
        ctrl_o.wb_sel    = WB_MEM;
      end
      ST_MEM_WR: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.addr_sel  = 1'b1;
      end
      ST_R_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = B_REG;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      ST_R_WB: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.reg_dst   = DST_RD;
        ctrl_o.wb_sel    = WB_ALU;
      end
      ST_BR_DONE: begin
        ctrl_o.alu_a_sel     = 1'b1;
        ctrl_o.alu_op        = AOP_SUB;
        ctrl_o.pc_write_cond = 1'b1;
        ctrl_o.pc_sel        = PCS_ALUOUT;
      end
      ST_J_DONE: begin
        ctrl_o.pc_write = 1'b1;
        ctrl_o.pc_sel   = PCS_JUMP;
      end
      ST_JAL_DONE: begin
        ctrl_o.pc_write  = 1'b1;
        ctrl_o.pc_sel    = PCS_JUMP;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.reg_dst   = DST_RA;
        ctrl_o.wb_sel    = WB_PC; // PC already holds return address
      end
      ST_EXC: begin
        ctrl_o.alu_b_sel   = B_FOUR;
        ctrl_o.alu_op      = AOP_SUB; // PC-4 into EPC
        ctrl_o.epc_write   = 1'b1;
        ctrl_o.cause_write = 1'b1;
        ctrl_o.pc_write    = 1'b1;
        ctrl_o.pc_sel      = PCS_VEC;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    opcode_i,
  output logic [STATE_W-1:0] state_o,
  output logic               pc_write_o,
  output logic               pc_write_cond_o,
  output logic               mem_read_o,
  output logic               mem_write_o,
  output logic               addr_sel_o,
  output logic               ir_write_o,
  output logic               reg_write_o,
  output logic [SEL_W-1:0]   reg_dst_o,
  output logic [SEL_W-1:0]   wb_sel_o,
  output logic               alu_a_sel_o,
  output logic [SEL_W-1:0]   alu_b_sel_o,
  output logic [SEL_W-1:0]   alu_op_o,
  output logic [SEL_W-1:0]   pc_sel_o,
  output logic               epc_write_o,
  output logic               cause_write_o
);
  state_e   state_q, state_d;
  op_info_t info;
  ctrl_t    ctrl;

  mc_op_classify i_classify (.opcode_i(opcode_i), .info_o(info));
  mc_next_state  i_next     (.state_i(state_q), .info_i(info), .next_o(state_d));
  mc_ctrl_decode i_decode   (.state_i(state_q), .ctrl_o(ctrl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o         = state_q;
  assign pc_write_o      = ctrl.pc_write;
  assign pc_write_cond_o = ctrl.pc_write_cond;
  assign mem_read_o      = ctrl.mem_read;
  assign mem_write_o     = ctrl.mem_write;
  assign addr_sel_o      = ctrl.addr_sel;
  assign ir_write_o      = ctrl.ir_write;
  assign reg_write_o     = ctrl.reg_write;
  assign reg_dst_o       = ctrl.reg_dst;
  assign wb_sel_o        = ctrl.wb_sel;
  assign alu_a_sel_o     = ctrl.alu_a_sel;
  assign alu_b_sel_o     = ctrl.alu_b_sel;
  assign alu_op_o        = ctrl.alu_op;
  assign pc_sel_o        = ctrl.pc_sel;
  assign epc_write_o     = ctrl.epc_write;
  assign cause_write_o   = ctrl.cause_write;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk
  import mc_ctrl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OP_W-1:0]    opcode_i,
  input logic [STATE_W-1:0] state_o,
  input logic               pc_write_o,
  input logic               mem_read_o,
  input logic               mem_write_o,
  input logic               reg_write_o,
  input logic [SEL_W-1:0]   reg_dst_o,
  input logic [SEL_W-1:0]   pc_sel_o,
  input logic               epc_write_o,
  input logic               cause_write_o
);
  logic op_known, code_known, r_loop;

  assign op_known = opcode_i inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h23, 6'h2B};
  assign code_known = state_o inside {4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0101, 4'b0111,
                                      4'b0110, 4'b0100, 4'b1001, 4'b1011, 4'b1010, 4'b1000};
  assign r_loop = state_o inside {4'b0011, 4'b0010};

  assert_fetch_to_decode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'b0000 |=> state_o == 4'b0001);

  assert_r_loop_one_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_loop |=> $countones(state_o ^ $past(state_o)) == 1);

  assert_load_read_then_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'b0111 |=> state_o == 4'b0110);

  assert_no_mem_conflict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_read_o && mem_write_o));

  assert_link_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_dst_o == 2'd2 |-> reg_write_o && pc_write_o && pc_sel_o == 2'd2);

  assert_illegal_to_exc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'b0001 && !op_known) |=> state_o == 4'b1000);

  assert_exc_actions_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'b1000 |-> epc_write_o && cause_write_o && pc_write_o && pc_sel_o == 2'd3);

  assert_exc_returns_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'b1000 |=> state_o == 4'b0000);

  assert_legal_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_known);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .state_o(state_o),
  .pc_write_o(pc_write_o), .mem_read_o(mem_read_o), .mem_write_o(mem_write_o),
  .reg_write_o(reg_write_o), .reg_dst_o(reg_dst_o), .pc_sel_o(pc_sel_o),
  .epc_write_o(epc_write_o), .cause_write_o(cause_write_o)
);

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] state_o;
  logic       pc_write_o, pc_write_cond_o, mem_read_o, mem_write_o, addr_sel_o, ir_write_o;
  logic       reg_write_o, alu_a_sel_o, epc_write_o, cause_write_o;
  logic [1:0] reg_dst_o, wb_sel_o, alu_b_sel_o, alu_op_o, pc_sel_o;
  int n_chk = 0, n_bad = 0, r_toggles = 0;

  always #4 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .state_o(state_o),
    .pc_write_o(pc_write_o), .pc_write_cond_o(pc_write_cond_o), .mem_read_o(mem_read_o),
    .mem_write_o(mem_write_o), .addr_sel_o(addr_sel_o), .ir_write_o(ir_write_o),
    .reg_write_o(reg_write_o), .reg_dst_o(reg_dst_o), .wb_sel_o(wb_sel_o),
    .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
    .pc_sel_o(pc_sel_o), .epc_write_o(epc_write_o), .cause_write_o(cause_write_o)
  );

  wire [19:0] ctrl_vec = {pc_write_o, pc_write_cond_o, mem_read_o, mem_write_o, addr_sel_o,
                          ir_write_o, reg_write_o, reg_dst_o, wb_sel_o, alu_a_sel_o,
                          alu_b_sel_o, alu_op_o, pc_sel_o, epc_write_o, cause_write_o};

  // Expected control vector per state, from the requirement text
  function automatic logic [19:0] exp_ctrl(input logic [3:0] s);
    logic pw = 0, pwc = 0, mr = 0, mw = 0, ad = 0, irw = 0, rw = 0, sa = 0, ep = 0, cw = 0;
    logic [1:0] rd = 0, wb = 0, sb = 0, op = 0, ps = 0;
    case (s)
      4'b0000: begin pw = 1; mr = 1; irw = 1; sb = 1; end
      4'b0001: sb = 3;
      4'b0101: begin sa = 1; sb = 2; end
      4'b0111: begin mr = 1; ad = 1; end
      4'b0110: begin rw = 1; wb = 1; end
      4'b0100: begin mw = 1; ad = 1; end
      4'b0011: begin sa = 1; op = 2; end
      4'b0010: begin rw = 1; rd = 1; end
      4'b1001: begin sa = 1; op = 1; pwc = 1; ps = 1; end
      4'b1011: begin pw = 1; ps = 2; end
      4'b1010: begin pw = 1; ps = 2; rw = 1; rd = 2; wb = 2; end
      4'b1000: begin pw = 1; ps = 3; sb = 1; op = 1; ep = 1; cw = 1; end
      default: ;
    endcase
    return {pw, pwc, mr, mw, ad, irw, rw, rd, wb, sa, sb, op, ps, ep, cw};
  endfunction

  task automatic check_eq(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input logic [3:0] s);
    check_eq({tag, " state"}, 20'(state_o), 20'(s));
    check_eq({tag, " ctrl"}, ctrl_vec, exp_ctrl(s));
  endtask

  // Called at a negedge with the machine in fetch
  task automatic run_instr(input string tag, input logic [5:0] op, input int n,
                           input logic [3:0] seq [5], input bit gray);
    logic [3:0] prev = 4'b0000;
    opcode = op;
    for (int i = 0; i < n; i++) begin
      check_state(tag, seq[i]);
      if (gray && i > 0) begin
        check_eq({tag, " one-bit toggle"}, 20'($countones(state_o ^ prev)), 20'd1);
        r_toggles += $countones(state_o ^ prev);
      end
      prev = state_o;
      @(negedge clk);
    end
    check_state({tag, " return"}, 4'b0000);
    if (gray) begin
      check_eq({tag, " one-bit toggle back"}, 20'($countones(state_o ^ prev)), 20'd1);
      r_toggles += $countones(state_o ^ prev);
    end
  endtask

  task automatic test_reset;
    #1;
    check_state("R2 in reset", 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    check_state("R2 after release", 4'b0000);
  endtask

  task automatic test_rtype;
    r_toggles = 0;
    run_instr("R4 rtype", 6'h00, 4, '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0000}, 1'b1);
    check_eq("R4 loop toggle total", 20'(r_toggles), 20'd4);
    run_instr("R3 R4 rtype again", 6'h00, 4, '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0000}, 1'b1);
  endtask

  task automatic test_load;
    run_instr("R5 load", 6'h23, 5, '{4'b0000, 4'b0001, 4'b0101, 4'b0111, 4'b0110}, 1'b0);
  endtask

  task automatic test_store;
    run_instr("R6 store", 6'h2B, 4, '{4'b0000, 4'b0001, 4'b0101, 4'b0100, 4'b0000}, 1'b0);
  endtask

  task automatic test_branch;
    run_instr("R7 branch", 6'h04, 3, '{4'b0000, 4'b0001, 4'b1001, 4'b0000, 4'b0000}, 1'b0);
  endtask

  task automatic test_jump;
    run_instr("R8 jump", 6'h02, 3, '{4'b0000, 4'b0001, 4'b1011, 4'b0000, 4'b0000}, 1'b0);
  endtask

  task automatic test_link;
    run_instr("R9 jump-link", 6'h03, 3, '{4'b0000, 4'b0001, 4'b1010, 4'b0000, 4'b0000}, 1'b0);
  endtask

  task automatic test_illegal;
    logic [5:0] ops [6] = '{6'h01, 6'h05, 6'h22, 6'h2A, 6'h2C, 6'h3F};
    foreach (ops[k])
      run_instr("R1 R10 illegal", ops[k], 3, '{4'b0000, 4'b0001, 4'b1000, 4'b0000, 4'b0000}, 1'b0);
  endtask

  task automatic test_async_reset;
    opcode = 6'h23;
    @(negedge clk);
    @(negedge clk);
    check_state("R5 load mid-flight", 4'b0101);
    rst_ni = 1'b0;
    #1;
    check_state("R2 async reset", 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    run_instr("R2 R11 after reset", 6'h00, 4, '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0000}, 1'b1);
  endtask

  initial begin
    test_reset();
    test_rtype();
    test_load();
    test_store();
    test_branch();
    test_jump();
    test_link();
    test_illegal();
    test_async_reset();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule